// File: doc/BRIEF.md
# Level-Based Interrupt Acceptance Unit

This block sits beside a CPU core and decides, every cycle, whether one of its peripheral interrupt request lines should be taken. It holds a global enable flag, the core's current 2-bit interrupt level, and a 2-bit priority level for each request source. The source levels are packed into a small bank of byte-wide level registers. A pending request qualifies only when the enable flag is set and the request's level is strictly below the current level. Level 0 is the most urgent. Level 3 is the value used while the main program runs, so a source programmed to 3 is never taken.

Among the qualifying requests, a fixed arbiter picks the one with the lowest level value. If levels tie, the lowest source index wins. The winner's index and level are driven out combinationally with an accept strobe. When the core acknowledges an accepted request, the unit raises the core's current level to the winner's level. This masks the same and less urgent levels until software writes the current level back.

Top module: `irq_accept_top`

## Requirements
- R1: After reset the enable flag is 0, the current level is 3 and every source level is 3. With every request line high, accept stays 0 before and after the enable flag is set, until a source level is programmed.
- R2: A pulse on `en_set` sets the enable flag at the next clock edge, and a pulse on `en_clr` clears it. When both are high in the same cycle, the flag ends up 0.
- R3: While the enable flag is 0, `accept` is 0 whatever the request lines and levels are.
- R4: A request qualifies only if its level is strictly less than the current level. A source at level 3 is never accepted, and a current level of 0 blocks every source.
- R5: Level register `cfg_sel`=n holds sources 4n to 4n+3. Source 4n+k sits in bits [2k+1:2k] of that register. A write with `cfg_we` takes effect at the next clock edge.
- R6: Among qualifying requests, the one with the numerically lowest level wins. Its index appears on `win_idx` and its level on `win_lvl`.
- R7: When several qualifying requests share the lowest level, the lowest source index wins.
- R8: `ack` in a cycle where `accept` is 1 loads the current level with `win_lvl` at the next edge. `ack` while `accept` is 0 leaves the current level unchanged.
- R9: `lvl_we` loads the current level with `lvl_wdata` at the next edge. If an accepted `ack` occurs in the same cycle, the acknowledged level is loaded instead.
- R10: While `accept` is 0, `win_idx` is 0 and `win_lvl` is 3.
- R11: `accept`, `win_idx` and `win_lvl` follow a change on the request lines in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req | input | NUM_SRC | Request lines, bit i for source i |
| en_set | input | 1 | Set the global enable flag |
| en_clr | input | 1 | Clear the global enable flag (wins over set) |
| cfg_we | input | 1 | Write strobe for a level register |
| cfg_sel | input | SEL_W | Level register index |
| cfg_wdata | input | SRC_PER_REG*2 | Packed source levels to write |
| lvl_we | input | 1 | Write strobe for the current level |
| lvl_wdata | input | 2 | New current level |
| ack | input | 1 | Core takes the accepted interrupt |
| accept | output | 1 | A request qualifies this cycle |
| win_idx | output | IDX_W | Index of the winning source |
| win_lvl | output | 2 | Level of the winning source |

## Verification
The bench builds the block with its default parameters: 16 sources and four sources per register, which gives four level registers. This reaches the top and bottom registers of the packing, so the field placement at both ends of the index range is exercised. It also allows same-level ties between sources in different registers and strict-below comparisons at every current level from 0 to 3. With these values the bench can also drive an acknowledge and a current-level write in the same cycle and observe, at the accept output, which of the two took effect.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] irq_lvl_t;
  // Least urgent level: also the idle value of the current level
  localparam irq_lvl_t LVL_IDLE = '1;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SRC_PER_REG = 4,
  localparam int NUM_REGS   = NUM_SRC / SRC_PER_REG,
  localparam int SEL_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int REG_W      = SRC_PER_REG * LVL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [REG_W-1:0]         cfg_wdata,
  output logic [NUM_SRC*LVL_W-1:0] src_lvl_flat
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [REG_W-1:0] reg_q;
    logic [REG_W-1:0] reg_d;
    logic             reg_en;

    always_comb begin
      reg_en = cfg_we && (cfg_sel == SEL_W'(r));
      reg_d  = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q <= {SRC_PER_REG{LVL_IDLE}};
      end else if (reg_en) begin
        reg_q <= reg_d;
      end
    end

    assign src_lvl_flat[r*REG_W +: REG_W] = reg_q;
  end
endmodule

// File: rtl/irq_ctrl_state.sv
module irq_ctrl_state
  import irq_accept_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_set,
  input  logic     en_clr,
  input  logic     lvl_we,
  input  irq_lvl_t lvl_wdata,
  input  logic     take,
  input  irq_lvl_t take_lvl,
  output logic     ie_q,
  output irq_lvl_t cur_lvl_q
);
  logic     ie_d;
  logic     ie_en;
  irq_lvl_t cur_lvl_d;
  logic     cur_lvl_en;

  always_comb begin
    ie_en = en_set || en_clr;
    ie_d  = !en_clr;
  end

  always_comb begin
    cur_lvl_en = take || lvl_we;
    if (take) begin
      cur_lvl_d = take_lvl;
    end else begin
      cur_lvl_d = lvl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (ie_en) begin
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl_q <= LVL_IDLE;
    end else if (cur_lvl_en) begin
      cur_lvl_q <= cur_lvl_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       irq_req,
  input  logic [NUM_SRC*LVL_W-1:0] src_lvl_flat,
  input  logic                     ie,
  input  irq_lvl_t                 cur_lvl,
  output logic                     accept,
  output logic [IDX_W-1:0]         win_idx,
  output irq_lvl_t                 win_lvl
);
  logic [NUM_SRC-1:0] elig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = ie && irq_req[i] &&
                     (src_lvl_flat[i*LVL_W +: LVL_W] < cur_lvl);
  end

  always_comb begin
    logic     found;
    irq_lvl_t best_lvl;
    logic [IDX_W-1:0] best_idx;
    found    = 1'b0;
    best_lvl = LVL_IDLE;
    best_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (elig[i] && (!found || (src_lvl_flat[i*LVL_W +: LVL_W] < best_lvl))) begin
        found    = 1'b1;
        best_lvl = src_lvl_flat[i*LVL_W +: LVL_W];
        best_idx = IDX_W'(i);
      end
    end
    accept  = found;
    win_idx = best_idx;
    win_lvl = best_lvl;
  end
endmodule

// File: rtl/irq_accept_top.sv
module irq_accept_top
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SRC_PER_REG = 4,
  localparam int NUM_REGS   = NUM_SRC / SRC_PER_REG,
  localparam int SEL_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int REG_W      = SRC_PER_REG * LVL_W,
  localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               en_set,
  input  logic               en_clr,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               lvl_we,
  input  logic [LVL_W-1:0]   lvl_wdata,
  input  logic               ack,
  output logic               accept,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl
);
  logic                     rst_n_s;
  logic [NUM_SRC*LVL_W-1:0] src_lvl_flat;
  logic                     ie_q;
  irq_lvl_t                 cur_lvl_q;
  logic                     take;

  irq_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  irq_lvl_regs #(
    .NUM_SRC     (NUM_SRC),
    .SRC_PER_REG (SRC_PER_REG)
  ) u_lvl_regs (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .src_lvl_flat (src_lvl_flat)
  );

  assign take = ack && accept;

  irq_ctrl_state u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .lvl_we    (lvl_we),
    .lvl_wdata (lvl_wdata),
    .take      (take),
    .take_lvl  (win_lvl),
    .ie_q      (ie_q),
    .cur_lvl_q (cur_lvl_q)
  );

  irq_arbiter #(
    .NUM_SRC (NUM_SRC)
  ) u_arb (
    .irq_req      (irq_req),
    .src_lvl_flat (src_lvl_flat),
    .ie           (ie_q),
    .cur_lvl      (cur_lvl_q),
    .accept       (accept),
    .win_idx      (win_idx),
    .win_lvl      (win_lvl)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               en_set,
  input logic               en_clr,
  input logic               lvl_we,
  input irq_lvl_t           lvl_wdata,
  input logic               ack,
  input logic               accept,
  input logic [IDX_W-1:0]   win_idx,
  input irq_lvl_t           win_lvl,
  input logic               ie_q,
  input irq_lvl_t           cur_lvl_q
);
  a_r3_disabled_no_accept: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ie_q |-> !accept);

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    en_clr |=> !ie_q);

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en_set && !en_clr) |=> ie_q);

  a_r4_strict_below: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |-> (win_lvl < cur_lvl_q));

  a_r4_floor_blocks: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cur_lvl_q == '0) |-> !accept);

  a_r6_winner_pending: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |-> irq_req[win_idx]);

  a_r8_ack_loads_level: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack && accept) |=> (cur_lvl_q == $past(win_lvl)));

  a_r9_level_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lvl_we && !(ack && accept)) |=> (cur_lvl_q == $past(lvl_wdata)));

  a_r10_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n_s)
    !accept |-> ((win_idx == '0) && (win_lvl == LVL_IDLE)));
endmodule

bind irq_accept_top irq_accept_chk #(
  .NUM_SRC (NUM_SRC)
) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .irq_req   (irq_req),
  .en_set    (en_set),
  .en_clr    (en_clr),
  .lvl_we    (lvl_we),
  .lvl_wdata (lvl_wdata),
  .ack       (ack),
  .accept    (accept),
  .win_idx   (win_idx),
  .win_lvl   (win_lvl),
  .ie_q      (ie_q),
  .cur_lvl_q (cur_lvl_q)
);

// File: tb/irq_accept_top_bench.sv
module irq_accept_top_bench;
  localparam int CLK_PERIOD = 20;

  logic        clk;
  logic        rst_n;
  logic [15:0] irq_req;
  logic        en_set, en_clr, cfg_we, lvl_we, ack;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [1:0]  lvl_wdata;
  logic        accept;
  logic [3:0]  win_idx;
  logic [1:0]  win_lvl;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  irq_accept_top u_irq_accept_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .lvl_we    (lvl_we),
    .lvl_wdata (lvl_wdata),
    .ack       (ack),
    .accept    (accept),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive request lines at a falling edge, sample after settling
  task automatic look(input logic [15:0] r);
    @(negedge clk);
    irq_req = r;
    #1;
  endtask

  task automatic expect_out(input string tag, input int a, input int i, input int l);
    check({tag, " accept"}, int'(accept), a);
    check({tag, " win_idx"}, int'(win_idx), i);
    check({tag, " win_lvl"}, int'(win_lvl), l);
  endtask

  task automatic set_ie();
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_lvl(input logic [1:0] v);
    @(negedge clk); lvl_we = 1'b1; lvl_wdata = v;
    @(negedge clk); lvl_we = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset_state();
    look(16'h0000);
    expect_out("R10 idle", 0, 0, 3);
    look(16'hFFFF);
    check("R1 disabled after reset", int'(accept), 0);
    set_ie();
    look(16'hFFFF);
    check("R1 unprogrammed sources", int'(accept), 0);
  endtask

  // levels: s0=2 s1=1 s2=0 s3=3 s4=1 s5=1 s8=2 s12=0, rest 3
  task automatic t_program_map();
    wr_cfg(2'd0, 8'hC6);
    wr_cfg(2'd1, 8'hF5);
    wr_cfg(2'd2, 8'hFE);
    wr_cfg(2'd3, 8'hFC);
    look(16'h1000);
    expect_out("R5 top register low field", 1, 12, 0);
    look(16'h0100);
    expect_out("R5 register 2 field", 1, 8, 2);
    look(16'h0008);
    check("R4 level 3 never taken", int'(accept), 0);
  endtask

  task automatic t_enable();
    @(negedge clk); en_set = 1'b1; en_clr = 1'b1;
    @(negedge clk); en_set = 1'b0; en_clr = 1'b0;
    look(16'h0002);
    check("R2 clear wins over set", int'(accept), 0);
    look(16'h1007);
    check("R3 disabled blocks all", int'(accept), 0);
    set_ie();
    look(16'h0002);
    expect_out("R2 set enables", 1, 1, 1);
  endtask

  task automatic t_strict();
    wr_lvl(2'd2);
    look(16'h0001);
    check("R4 equal level rejected", int'(accept), 0);
    look(16'h0002);
    expect_out("R4 below level taken", 1, 1, 1);
    wr_lvl(2'd3);
  endtask

  task automatic t_priority();
    look(16'h0007);
    expect_out("R6 lowest level wins", 1, 2, 0);
    look(16'h0103);
    expect_out("R6 level 1 beats level 2", 1, 1, 1);
  endtask

  task automatic t_tie();
    look(16'h0030);
    expect_out("R7 tie lower index", 1, 4, 1);
    look(16'h1004);
    expect_out("R7 tie across registers", 1, 2, 0);
    // mid-cycle change, no edge in between
    #3 irq_req = 16'h0100;
    #1;
    expect_out("R11 combinational follow", 1, 8, 2);
  endtask

  task automatic t_ack();
    look(16'h0002);
    pulse_ack();
    look(16'h0010);
    check("R8 same level masked after ack", int'(accept), 0);
    look(16'h0004);
    expect_out("R8 more urgent still taken", 1, 2, 0);
    wr_lvl(2'd3);
    look(16'h0000);
    pulse_ack();
    look(16'h0001);
    expect_out("R8 ack without accept ignored", 1, 0, 2);
  endtask

  task automatic t_ack_vs_write();
    @(negedge clk);
    irq_req = 16'h0004; ack = 1'b1; lvl_we = 1'b1; lvl_wdata = 2'd3;
    @(negedge clk);
    ack = 1'b0; lvl_we = 1'b0;
    #1;
    check("R9 ack wins over level write", int'(accept), 0);
    look(16'h1000);
    check("R4 current level 0 blocks level 0", int'(accept), 0);
    wr_lvl(2'd1);
    look(16'h0004);
    expect_out("R9 level write applies", 1, 2, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; en_set = 0; en_clr = 0; cfg_we = 0;
    cfg_sel = '0; cfg_wdata = '0; lvl_we = 0; lvl_wdata = '0; ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_program_map();
    t_enable();
    t_strict();
    t_priority();
    t_tie();
    t_ack();
    t_ack_vs_write();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule